// File: doc/BRIEF.md
# Bitfield and Byte Permute Unit

This datapath unit serves a 32-bit RISC core. It carries out the bit-manipulation operations: two forms of right rotation, field extract, field insert, swapping the bytes inside each halfword, and sign extension of a byte or a halfword. The core supplies a source operand, a second operand, a field position, a field size, an immediate shift amount and a 3-bit operation code. The unit returns one 32-bit result. The second operand is the insert destination, and its low bits give the amount for the register-driven rotate.

The result path is combinational. A parameter can place a register on the result for timing. With `REG_OUT` = 1 the result and the field flag appear one clock after the inputs, and reset clears both. With `REG_OUT` = 0 they follow the inputs in the same cycle. Extract and insert check the field they are given. If the field runs past bit 31, the unit raises an error flag and the result is don't-care.

Top module: `bit_permute_unit`

## Requirements
- R1: With op code 0, the result is `src` rotated right by `shamt`. Bits that leave at bit 0 come back in at bit 31. A shift of 0 returns `src` unchanged.
- R2: With op code 1, the result is `src` rotated right by `opb[4:0]`. Bits 31:5 of `opb` have no effect.
- R3: With op code 2, the result is `src` shifted right by `pos` and ANDed with a mask of `size` ones, with the upper bits zero.
- R4: With op code 3, the result holds `opb` outside the field. Inside the field, bits `pos` to `pos+size-1` carry the low `size` bits of `src`.
- R5: A `size` of 32 (with `pos` 0) gives a full 32-bit mask, so extract returns `src` and insert returns `src`. A `size` of 0 gives an empty mask: extract returns 0 and insert returns `opb`.
- R6: `field_err` is 1 exactly when the op code is 2 or 3 and `pos+size` is greater than 32. The result is then not defined.
- R7: With op code 4, the result swaps bytes 0 and 1 and swaps bytes 2 and 3 of `src`.
- R8: With op code 5, the result is `src[7:0]` with bit 7 copied into bits 31:8.
- R9: With op code 6, the result is `src[15:0]` with bit 15 copied into bits 31:16.
- R10: With op code 7, the result equals `src`.
- R11: With `REG_OUT` = 1, the outputs show the inputs of the previous clock, and `result` and `field_err` read 0 while `rst_n` is low. With `REG_OUT` = 0, the outputs follow the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (0..7) |
| src | input | 32 | Source operand |
| opb | input | 32 | Insert destination; low 5 bits are the variable rotate amount |
| pos | input | 5 | Field low bit position |
| size | input | 6 | Field width, 0 to 32 |
| shamt | input | 5 | Immediate rotate amount |
| result | output | 32 | Operation result |
| field_err | output | 1 | Field exceeds bit 31 on extract or insert |

## Verification
The bench builds two copies of the unit side by side. One has `REG_OUT` = 1, which is needed to test the reset value and the one-cycle latency. The other has `REG_OUT` = 0, so the combinational path is checked in the same cycle as its stimulus. Both copies receive the same stimulus: every legal pair of position and size for extract and insert, fields placed just past bit 31, the rotate amounts 0 and 31, and random operands for all eight codes.

// File: rtl/bit_permute_unit.sv
module bit_permute_unit #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_sel,
  input  logic [31:0] src,
  input  logic [31:0] opb,
  input  logic [4:0]  pos,
  input  logic [5:0]  size,
  input  logic [4:0]  shamt,
  output logic [31:0] result,
  output logic        field_err
);
  localparam int W = 32;

  logic [4:0]   rot_amt;
  logic [2*W-1:0] rot_wide;
  logic [W:0]   ones_wide;
  logic [W-1:0] fmask, ins_mask, nxt;
  logic [6:0]   field_end;
  logic         is_field, err_nxt;

  assign rot_amt   = (op_sel == 3'd1) ? opb[4:0] : shamt;
  assign rot_wide  = {src, src} >> rot_amt;
  assign ones_wide = ({{W{1'b0}}, 1'b1} << size) - {{W{1'b0}}, 1'b1};
  assign fmask     = ones_wide[W-1:0];
  assign ins_mask  = fmask << pos;
  assign field_end = {2'b00, pos} + {1'b0, size};
  assign is_field  = (op_sel == 3'd2) || (op_sel == 3'd3);
  assign err_nxt   = is_field && (field_end > 7'd32);

  always_comb begin
    case (op_sel)
      3'd0, 3'd1: nxt = rot_wide[W-1:0];
      3'd2:       nxt = (src >> pos) & fmask;
      3'd3:       nxt = (opb & ~ins_mask) | ((src << pos) & ins_mask);
      3'd4:       nxt = {src[23:16], src[31:24], src[7:0], src[15:8]};
      3'd5:       nxt = {{24{src[7]}}, src[7:0]};
      3'd6:       nxt = {{16{src[15]}}, src[15:0]};
      default:    nxt = src;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          field_err <= 1'b0;
        end else begin
          result    <= nxt;
          field_err <= err_nxt;
        end
      end

      // R1
      rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && shamt == 5'd0) |=> result == $past(src));
      // R5
      full_extract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && pos == 5'd0 && size == 6'd32) |=> result == $past(src));
      // R6
      field_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2] || op_sel[1:0] == 2'b00 || op_sel[1:0] == 2'b01) |=> !field_err);
      // R7
      bswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4) |=> (result[15:8] == $past(src[7:0])
                              && result[31:24] == $past(src[23:16])));
      // R8
      sext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5) |=> (result[31:8] == {24{$past(src[7])}}));
      // R9
      sext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd6) |=> (result[31:16] == {16{$past(src[15])}}));
      // R10
      pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> result == $past(src));
    end else begin : g_comb
      assign result    = nxt;
      assign field_err = err_nxt;
    end
  endgenerate
endmodule

// File: tb/bit_permute_unit_test.sv
module bit_permute_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] src = '0, opb = '0;
  logic [4:0]  pos = '0, shamt = '0;
  logic [5:0]  size = '0;
  logic [31:0] res_r, res_c;
  logic        err_r, err_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bit_permute_unit #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src(src), .opb(opb),
    .pos(pos), .size(size), .shamt(shamt), .result(res_r), .field_err(err_r));

  bit_permute_unit #(.REG_OUT(1'b0)) uut_c (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src(src), .opb(opb),
    .pos(pos), .size(size), .shamt(shamt), .result(res_c), .field_err(err_c));

  function automatic logic [31:0] ref_rot(input logic [31:0] x, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32];
    return r;
  endfunction

  function automatic logic [31:0] ref_ext(input logic [31:0] x, input int p, input int s);
    logic [31:0] r = '0;
    for (int i = 0; i < s; i++) if (i + p < 32) r[i] = x[i + p];
    return r;
  endfunction

  function automatic logic [31:0] ref_ins(input logic [31:0] a, input logic [31:0] d,
                                          input int p, input int s);
    logic [31:0] r = d;
    for (int i = 0; i < s; i++) if (i + p < 32) r[i + p] = a[i];
    return r;
  endfunction

  function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input int p, input int s, input int sh);
    case (op)
      3'd0: return ref_rot(a, sh);
      3'd1: return ref_rot(a, int'(b[4:0]));
      3'd2: return ref_ext(a, p, s);
      3'd3: return ref_ins(a, b, p, s);
      3'd4: return {a[23:16], a[31:24], a[7:0], a[15:8]};
      3'd5: return {{24{a[7]}}, a[7:0]};
      3'd6: return {{16{a[15]}}, a[15:0]};
      default: return a;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R7"; 3'd5: return "R8"; 3'd6: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                     input int p, input int s, input int sh, input string req);
    logic [31:0] exp;
    logic eerr;
    @(negedge clk);
    op_sel = op; src = a; opb = b; pos = p[4:0]; size = s[5:0]; shamt = sh[4:0];
    exp  = ref_res(op, a, b, p, s, sh);
    eerr = (op == 3'd2 || op == 3'd3) && (p + s > 32);
    #1;
    check({req, "/R6 comb err"}, {31'd0, err_c}, {31'd0, eerr});
    if (!eerr) check({req, " comb"}, res_c, exp);
    @(negedge clk);
    check({req, "/R11 reg err"}, {31'd0, err_r}, {31'd0, eerr});
    if (!eerr) check({req, "/R11 reg"}, res_r, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op_sel = 3'd7; src = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R11 reset result", res_r, 32'h0);
    check("R11 reset err", {31'd0, err_r}, 32'h0);
    rst_n = 1'b1;

    run(3'd0, 32'h8000_0001, 0, 0, 0, 0,  "R1 zero");
    run(3'd0, 32'h8000_0001, 0, 0, 0, 1,  "R1 one");
    run(3'd0, 32'h1234_5678, 0, 0, 0, 31, "R1 max");
    run(3'd1, 32'h1234_5678, 32'hFFFF_FFE4, 0, 0, 0, "R2 high bits");
    run(3'd1, 32'hCAFE_F00D, 32'h0000_0020, 0, 0, 0, "R2 wrap 32");
    run(3'd2, 32'hA5A5_5A5A, 0, 0, 32, 0, "R5 ext full");
    run(3'd3, 32'hA5A5_5A5A, 32'h1111_1111, 0, 32, 0, "R5 ins full");
    run(3'd2, 32'hFFFF_FFFF, 0, 7, 0, 0, "R5 ext empty");
    run(3'd3, 32'hFFFF_FFFF, 32'h1357_9BDF, 9, 0, 0, "R5 ins empty");
    run(3'd2, 32'hFFFF_FFFF, 0, 1, 32, 0, "R6 ext over");
    run(3'd3, 32'hFFFF_FFFF, 0, 31, 2, 0, "R6 ins over");
    run(3'd2, 32'h8000_0000, 0, 31, 1, 0, "R3 top bit");
    run(3'd4, 32'h1122_3344, 0, 0, 0, 0, "R7 bswap");
    run(3'd5, 32'h0000_0080, 0, 0, 0, 0, "R8 neg");
    run(3'd5, 32'hFFFF_FF7F, 0, 0, 0, 0, "R8 pos");
    run(3'd6, 32'h0000_8000, 0, 0, 0, 0, "R9 neg");
    run(3'd6, 32'hFFFF_7FFF, 0, 0, 0, 0, "R9 pos");
    run(3'd7, 32'h0BAD_CAFE, 0, 31, 32, 31, "R10 pass");

    for (int p = 0; p < 32; p++)
      for (int s = 0; s <= 32 - p; s++) begin
        run(3'd2, $urandom, $urandom, p, s, 0, "R3 sweep");
        run(3'd3, $urandom, $urandom, p, s, 0, "R4 sweep");
      end

    for (int n = 0; n < 1500; n++) begin
      logic [2:0] op;
      int p, s;
      op = 3'($urandom % 8);
      p  = int'($urandom % 32);
      s  = ($urandom % 10 == 0) ? int'($urandom % 33) : int'($urandom % (33 - p));
      run(op, $urandom, $urandom, p, s, int'($urandom % 32), req_of(op));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule